// File: doc/BRIEF.md
# Priority Interrupt Encoder with Restart Opcode Output

This block sits between eight device request lines and a processor's single interrupt input. Each request line is captured into a pending latch, so a one-cycle pulse is not lost. The highest-numbered pending request is the candidate. It is forwarded only when it strictly outranks a programmable current-service level. The block then raises its interrupt output, and only while the processor reports that interrupts are enabled. A request that loses the comparison stays latched and competes again whenever the level or the other requests change.

When the processor acknowledges, the block freezes the number of the candidate as the grant. During the third bus state of the acknowledge cycle, it drives an executable one-byte restart opcode with the pattern 11 NNN 111, where NNN is the grant. The processor multiplies NNN by 8 to reach a service address from 00h to 38h. The latch of the granted request clears when the acknowledge strobe falls. The level is loaded by software through a separate write strobe.

A four-state machine controls the handshake. IDLE moves to RAISE when an eligible request exists. RAISE moves to ACK when the acknowledge strobe rises, and falls back to IDLE if no request is eligible any longer. ACK moves to DRIVE when the third-state strobe is seen, and back to IDLE if the acknowledge is withdrawn first. DRIVE moves to IDLE when the acknowledge strobe falls, and this transition clears the grant's latch.

Top module: `prio_restart_encoder`

## Requirements
- R1: A synchronous reset clears every pending latch, sets the level to 0, returns the machine to IDLE, and holds the interrupt output and the bus-valid flag low.
- R2: A request held high for a single clock cycle is latched and later produces an interrupt without being held any longer.
- R3: Among several pending requests, the highest-numbered one is granted first. Request 7 has the highest priority and request 0 the lowest.
- R4: Request n is eligible only when n is greater than or equal to the level value L (0 to 15). L = 0 admits every request, L = 8 or more admits none, and a request with n < L never raises the interrupt.
- R5: A request that is blocked by the level remains pending, and it raises the interrupt once the level is lowered below or to its number.
- R6: The interrupt output is high only while the interrupt-enable input is high, and it follows that input in the same cycle.
- R7: During the acknowledge, the bus output carries {2'b11, grant[2:0], 3'b111} (C7h + 8·n). It is valid from the cycle in which the third-state strobe is high and stays valid until the acknowledge strobe falls. It is not valid in the acknowledge cycles before that strobe.
- R8: The bus-valid flag is low, and the bus output reads 00h, whenever the acknowledge strobe is low.
- R9: The granted request's latch clears when the acknowledge strobe falls in DRIVE. Other pending requests are kept and are served afterwards.
- R10: The level changes only on a cycle where its write strobe is high. Data presented without the strobe has no effect.
- R11: The grant is frozen when the acknowledge begins. A higher request that arrives during the acknowledge does not alter the opcode; it is served on the next interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | 8 | Device request lines, active high |
| inte_i | input | 1 | Processor interrupt-enable output |
| lvl_wr_i | input | 1 | Write strobe for the current-service level |
| lvl_din_i | input | 4 | New level value |
| inta_i | input | 1 | Interrupt acknowledge strobe |
| t3_i | input | 1 | Third bus state of the acknowledge cycle |
| intr_o | output | 1 | Interrupt request to the processor |
| data_o | output | 8 | Restart opcode, 00h when not valid |
| data_oe_o | output | 1 | Bus output valid |

## Verification
Each single request is swept against every level from 0 to 9. This separates the strict-outrank boundary (n equal to L passes, n below L is held) from the cases where all requests pass or none do. The blocked case then presents new level data without the strobe, and after that lowers the level properly, which shows that the request was held and not dropped. Every ordered pair of simultaneous requests is acknowledged twice, once for each request. This tells the priority order apart from the clearing of only the granted latch. A late higher request injected during an acknowledge distinguishes a frozen grant from a live encoder output.

// File: rtl/pri_pkg.sv
package pri_pkg;

    localparam int unsigned NUM_REQ = 8;
    localparam int unsigned IDX_W   = $clog2(NUM_REQ);
    localparam int unsigned LVL_W   = IDX_W + 1;
    localparam int unsigned OP_W    = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RAISE,
        ST_ACK,
        ST_DRIVE
    } ack_st_e;

    // restart opcode: 11 NNN 111
    function automatic logic [OP_W-1:0] restart_op(input logic [IDX_W-1:0] n);
        return {2'b11, n, 3'b111};
    endfunction

endpackage

// File: rtl/pri_req_latch.sv
module pri_req_latch #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req_i,
    input  logic          clr_en_i,
    input  logic [IW-1:0] clr_idx_i,
    output logic [N-1:0]  pend_o
);

    logic [N-1:0] clr_mask;
    logic [N-1:0] pend_q;

    for (genvar i = 0; i < N; i++) begin : g_clr
        assign clr_mask[i] = clr_en_i && (clr_idx_i == IW'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= (pend_q & ~clr_mask) | req_i;
        end
    end

    assign pend_o = pend_q;

endmodule

// File: rtl/pri_pick.sv
module pri_pick #(
    parameter int unsigned N  = 8,
    parameter int unsigned IW = 3
) (
    input  logic [N-1:0]  pend_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) begin
            if (pend_i[i]) begin
                idx_o = IW'(i);
            end
        end
    end

    assign any_o = |pend_i;

endmodule

// File: rtl/pri_ack_fsm.sv
module pri_ack_fsm
    import pri_pkg::*;
#(
    parameter int unsigned IW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          eligible_i,
    input  logic [IW-1:0] win_idx_i,
    input  logic          inta_i,
    input  logic          t3_i,
    output logic          raise_o,
    output logic          drive_o,
    output logic          clr_o,
    output logic [IW-1:0] grant_o
);

    ack_st_e       state_q;
    ack_st_e       state_d;
    logic [IW-1:0] grant_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            grant_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RAISE && inta_i) begin
                grant_q <= win_idx_i;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (eligible_i) state_d = ST_RAISE;
            end
            ST_RAISE: begin
                if (inta_i)           state_d = ST_ACK;
                else if (!eligible_i) state_d = ST_IDLE;
            end
            ST_ACK: begin
                if (!inta_i)   state_d = ST_IDLE;
                else if (t3_i) state_d = ST_DRIVE;
            end
            ST_DRIVE: begin
                if (!inta_i) state_d = ST_IDLE;
            end
        endcase
    end

    always_comb begin
        raise_o = 1'b0;
        drive_o = 1'b0;
        clr_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RAISE: raise_o = 1'b1;
            ST_ACK:   drive_o = inta_i && t3_i;
            ST_DRIVE: begin
                drive_o = inta_i;
                clr_o   = !inta_i;
            end
        endcase
    end

    assign grant_o = grant_q;

endmodule

// File: rtl/prio_restart_encoder.sv
module prio_restart_encoder
    import pri_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       req_i,
    input  logic             inte_i,
    input  logic             lvl_wr_i,
    input  logic [3:0]       lvl_din_i,
    input  logic             inta_i,
    input  logic             t3_i,
    output logic             intr_o,
    output logic [7:0]       data_o,
    output logic             data_oe_o
);

    logic [NUM_REQ-1:0] pend_q;
    logic [LVL_W-1:0]   lvl_q;
    logic               any_pend;
    logic [IDX_W-1:0]   win_idx;
    logic               eligible;
    logic               raise;
    logic               drive;
    logic               clr_en;
    logic [IDX_W-1:0]   grant;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
        end else if (lvl_wr_i) begin
            lvl_q <= lvl_din_i;
        end
    end

    pri_req_latch #(.N(NUM_REQ), .IW(IDX_W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .clr_en_i  (clr_en),
        .clr_idx_i (grant),
        .pend_o    (pend_q)
    );

    pri_pick #(.N(NUM_REQ), .IW(IDX_W)) u_pick (
        .pend_i (pend_q),
        .any_o  (any_pend),
        .idx_o  (win_idx)
    );

    // rank n+1 must exceed level L, i.e. n >= L
    assign eligible = any_pend && ({1'b0, win_idx} >= lvl_q);

    pri_ack_fsm #(.IW(IDX_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .eligible_i (eligible),
        .win_idx_i  (win_idx),
        .inta_i     (inta_i),
        .t3_i       (t3_i),
        .raise_o    (raise),
        .drive_o    (drive),
        .clr_o      (clr_en),
        .grant_o    (grant)
    );

    assign intr_o    = raise && inte_i;
    assign data_oe_o = drive;
    assign data_o    = drive ? restart_op(grant) : '0;

endmodule

// File: rtl/prio_restart_encoder_chk.sv
module prio_restart_encoder_chk (
    input logic       clk,
    input logic       rst,
    input logic       inte_i,
    input logic       inta_i,
    input logic       intr_o,
    input logic [7:0] data_o,
    input logic       data_oe_o,
    input logic [7:0] pend_q,
    input logic [3:0] lvl_q
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pend_q == 8'h00 && !intr_o && !data_oe_o && lvl_q == 4'd0));

    // R6
    intr_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
        intr_o |-> inte_i);

    // R4
    intr_outranks_chk: assert property (@(posedge clk) disable iff (rst)
        intr_o |-> ((pend_q >> lvl_q) != 8'h00));

    // R8
    valid_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> inta_i);

    // R8
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !data_oe_o |-> (data_o == 8'h00));

    // R7
    opcode_shape_chk: assert property (@(posedge clk) disable iff (rst)
        data_oe_o |-> (data_o[7:6] == 2'b11 && data_o[2:0] == 3'b111));

    // R11
    grant_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (data_oe_o && $past(data_oe_o)) |-> $stable(data_o));

endmodule

bind prio_restart_encoder prio_restart_encoder_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .inte_i    (inte_i),
    .inta_i    (inta_i),
    .intr_o    (intr_o),
    .data_o    (data_o),
    .data_oe_o (data_oe_o),
    .pend_q    (pend_q),
    .lvl_q     (lvl_q)
);

// File: tb/tb_prio_restart_encoder.sv
module tb_prio_restart_encoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] req_i = '0;
    logic       inte_i = 1'b0;
    logic       lvl_wr_i = 1'b0;
    logic [3:0] lvl_din_i = '0;
    logic       inta_i = 1'b0;
    logic       t3_i = 1'b0;
    logic       intr_o;
    logic [7:0] data_o;
    logic       data_oe_o;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    prio_restart_encoder dut (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .inte_i    (inte_i),
        .lvl_wr_i  (lvl_wr_i),
        .lvl_din_i (lvl_din_i),
        .inta_i    (inta_i),
        .t3_i      (t3_i),
        .intr_o    (intr_o),
        .data_o    (data_o),
        .data_oe_o (data_oe_o)
    );

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish (actual hung, expected done)");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cyc(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic do_reset();
        rst = 1'b1; req_i = '0; inte_i = 1'b0; lvl_wr_i = 1'b0;
        lvl_din_i = '0; inta_i = 1'b0; t3_i = 1'b0;
        cyc(2);
        rst = 1'b0;
        cyc(1);
    endtask

    task automatic wr_level(input int lv);
        lvl_wr_i = 1'b1;
        lvl_din_i = 4'(lv);
        cyc(1);
        lvl_wr_i = 1'b0;
    endtask

    task automatic pulse(input logic [7:0] m);
        req_i = m;
        cyc(1);
        req_i = '0;
    endtask

    task automatic ack_expect(input int n, input string tag);
        int op;
        op = 8'hC7 + 8 * n;
        inta_i = 1'b1;
        cyc(1);
        chk(data_oe_o == 1'b0, {tag, " R7 no valid before T3"}, data_oe_o, 0);
        chk(intr_o == 1'b0, {tag, " intr low in ack"}, intr_o, 0);
        t3_i = 1'b1;
        #1;
        chk(data_oe_o && data_o == 8'(op), {tag, " R7 opcode at T3"}, data_o, op);
        cyc(1);
        t3_i = 1'b0;
        #1;
        chk(data_oe_o && data_o == 8'(op), {tag, " R7 opcode held"}, data_o, op);
        inta_i = 1'b0;
        #1;
        chk(!data_oe_o && data_o == 8'h00, {tag, " R8 released"}, data_o, 0);
        cyc(1);
    endtask

    initial begin
        cyc(1);
        // single request against every level
        for (int lv = 0; lv < 10; lv++) begin
            for (int n = 0; n < 8; n++) begin
                do_reset();
                if (lv == 0 && n == 0) begin
                    chk(!intr_o && !data_oe_o && data_o == 0, "R1 reset outputs",
                        {intr_o, data_oe_o, data_o}, 0);
                    t3_i = 1'b1;
                    #1;
                    chk(!data_oe_o, "R8 t3 without ack", data_oe_o, 0);
                    t3_i = 1'b0;
                end
                wr_level(lv);
                pulse(8'(1 << n));
                chk(!intr_o, "R6 intr masked while disabled", intr_o, 0);
                inte_i = 1'b1;
                cyc(2);
                chk(intr_o == (n >= lv), "R4 R2 compare vs level", intr_o, int'(n >= lv));
                if (n >= lv) begin
                    ack_expect(n, "R7");
                    cyc(1);
                    chk(!intr_o, "R9 latch cleared", intr_o, 0);
                end else begin
                    lvl_din_i = 4'd0;
                    cyc(2);
                    chk(!intr_o, "R10 no write without strobe", intr_o, 0);
                    wr_level(0);
                    cyc(2);
                    chk(intr_o, "R5 held request served", intr_o, 1);
                    inte_i = 1'b0;
                    #1;
                    chk(!intr_o, "R6 follows enable", intr_o, 0);
                    inte_i = 1'b1;
                    #1;
                    ack_expect(n, "R5");
                end
            end
        end

        // every pair of simultaneous requests
        for (int a = 0; a < 8; a++) begin
            for (int b = a + 1; b < 8; b++) begin
                do_reset();
                pulse(8'((1 << a) | (1 << b)));
                inte_i = 1'b1;
                cyc(2);
                chk(intr_o, "R3 pair raises", intr_o, 1);
                ack_expect(b, "R3");
                cyc(2);
                chk(intr_o, "R9 lower kept", intr_o, 1);
                ack_expect(a, "R9");
            end
        end

        // higher request arriving during acknowledge
        for (int a = 0; a < 7; a++) begin
            do_reset();
            pulse(8'(1 << a));
            inte_i = 1'b1;
            cyc(2);
            inta_i = 1'b1;
            cyc(1);
            pulse(8'h80);
            t3_i = 1'b1;
            #1;
            chk(data_oe_o && data_o == 8'(8'hC7 + 8 * a), "R11 grant frozen", data_o, 8'hC7 + 8 * a);
            cyc(1);
            t3_i = 1'b0;
            inta_i = 1'b0;
            cyc(3);
            chk(intr_o, "R11 late request pending", intr_o, 1);
            ack_expect(7, "R11");
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule